// File: doc/BRIEF.md
# Serial ADC Host Reader

This block runs a 12-bit serial successive-approximation converter over a three-wire link. The link has an active-low select, a data clock and a serial data input. The block is clocked from a faster system clock. It divides the system clock down to a data clock whose half period is programmable. It drops select to open each conversion and discards the clock periods the converter spends acquiring and sending its leading null bit. It then shifts the result in most significant bit first and presents it as a parallel word with a one-cycle valid strobe.

A caller asks for a conversion with `req`. The caller may also set a short-cycle length `nbits`. In that case the block raises select as soon as the requested number of leading bits has arrived, and returns them left-justified. While `req` is held high the block runs frames back to back. Between frames, select stays high for exactly one data-clock period, so a full-length frame spans sixteen data-clock periods.

The controller has three states:
- `ST_IDLE`: select high, clock parked low.
- `ST_CONV`: select low, clock running.
- `ST_GAP`: select high for one data-clock period.

It has four transitions:
- IDLE→CONV on a request.
- CONV→GAP on the falling clock edge that follows the last wanted bit.
- GAP→CONV when the gap has elapsed and a request is new or pending.
- GAP→IDLE when the gap has elapsed with no request.

Top module: `adc_host_reader`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `result_valid` is 0 and `result` is 0.
- R2: Each high phase and each low phase of `sclk` lasts H system cycles. H is `half_cyc`, raised to 8 when it is smaller (8 covers 150 ns at a 20 ns system clock). H is latched when a frame starts.
- R3: The first rising `sclk` edge of a frame comes exactly H system cycles after `cs_n` falls.
- R4: A frame holds `cs_n` low for exactly 3+n data-clock periods, with 3+n rising `sclk` edges. The first three rising edges are ignored: two acquisition periods and the null bit. Rising edges 4 to 3+n deliver result bits 11, 10, and so on downward, most significant bit first. `sdi` passes through a two-stage synchronizer, and each bit is taken two system cycles after its rising edge. `cs_n` rises on the falling edge that ends the last wanted bit.
- R5: The bit count n is `nbits` clamped to the range 3 to 12. Values 0 to 2 give 3, and values 13 to 15 give 12.
- R6: `result` is an unsigned 12-bit field. Its bits [11:12-n] hold the n bits read, and all lower bits are 0. `result_bits` equals n.
- R7: `result_valid` is high for exactly one system cycle, in the first cycle with `cs_n` high after a frame.
- R8: Between back-to-back frames, `cs_n` stays high for exactly 2·H system cycles. With `req` held high and n=12, one frame plus its gap spans 16 data-clock periods.
- R9: A `req` seen during a frame or its gap is held and served once, right after the gap. Several requests during one frame give only one further frame.
- R10: `sclk` is 0 whenever `cs_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 1 | Conversion request, sampled each cycle |
| half_cyc | input | 12 | Data-clock half period in system cycles |
| nbits | input | 4 | Short-cycle bit count, clamped to 3..12 |
| sdi | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Active-low select to the converter |
| sclk | output | 1 | Data clock to the converter |
| result | output | 12 | Left-justified conversion result |
| result_bits | output | 4 | Number of valid leading bits in `result` |
| result_valid | output | 1 | One-cycle result strobe |

## Verification
A new request can arrive in the very cycle that a frame ends. In that cycle, the CONV→GAP transition fires and the result strobe is loaded, while the request must be parked rather than lost or taken at once. The bench counts the frame length from its own request and drives `req` high exactly on the closing clock edge. It then expects the strobe at that point and a second frame to open after a gap of exactly 2·H cycles. It also checks that extra requests in one frame collapse into a single follow-on frame.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CONV = 2'd1,
        ST_GAP  = 2'd2
    } rd_state_t;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/adc_rd_clkgen.sv
module adc_rd_clkgen #(
    parameter int DIV_W   = 12,
    parameter int CAP_DLY = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] half,
    output logic             sclk,
    output logic             cap,
    output logic             fall
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap = (cnt == half - DIV_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            sclk <= ~sclk;
        end else begin
            cnt  <= cnt + DIV_W'(1);
        end
    end

    // capture point sits CAP_DLY cycles into the high phase to cover the synchronizer
    assign cap  = en && sclk && (cnt == DIV_W'(CAP_DLY));
    assign fall = en && sclk && wrap;
endmodule

// File: rtl/adc_host_reader.sv
module adc_host_reader #(
    parameter int DIV_W       = 12,
    parameter int CLK_NS      = 20,
    parameter int SCLK_MIN_NS = 150,
    parameter int SYNC_STAGES = 2,
    parameter int RES_W       = 12,
    parameter int SKIP        = 3,
    parameter int MIN_BITS    = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req,
    input  logic [DIV_W-1:0]           half_cyc,
    input  logic [$clog2(RES_W+1)-1:0] nbits,
    input  logic                       sdi,
    output logic                       cs_n,
    output logic                       sclk,
    output logic [RES_W-1:0]           result,
    output logic [$clog2(RES_W+1)-1:0] result_bits,
    output logic                       result_valid
);
    import adc_rd_pkg::*;

    localparam int NB_W     = $clog2(RES_W+1);
    localparam int CNT_W    = $clog2(RES_W+SKIP+1);
    localparam int GAP_W    = DIV_W + 1;
    localparam int HALF_NS  = (SCLK_MIN_NS + CLK_NS - 1) / CLK_NS;
    localparam int MIN_HALF = (HALF_NS > SYNC_STAGES + 2) ? HALF_NS : SYNC_STAGES + 2;

    rd_state_t        state, nxt;
    logic [DIV_W-1:0] half_l, half_eff;
    logic [NB_W-1:0]  n_l, n_eff;
    logic [CNT_W-1:0] rise_cnt;
    logic [GAP_W-1:0] gcnt;
    logic [RES_W-1:0] acc;
    logic             pending, sdi_s, cap, fall, gen_en;
    logic             start, frame_end, gap_done;

    adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(sdi), .dout(sdi_s)
    );

    adc_rd_clkgen #(.DIV_W(DIV_W), .CAP_DLY(SYNC_STAGES)) u_gen (
        .clk(clk), .rst_n(rst_n), .en(gen_en), .half(half_l),
        .sclk(sclk), .cap(cap), .fall(fall)
    );

    always_comb begin
        half_eff = (half_cyc < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_cyc;
        if (nbits < NB_W'(MIN_BITS))   n_eff = NB_W'(MIN_BITS);
        else if (nbits > NB_W'(RES_W)) n_eff = NB_W'(RES_W);
        else                           n_eff = nbits;
    end

    assign gap_done  = (gcnt == GAP_W'({half_l, 1'b0}) - GAP_W'(1));
    assign frame_end = (state == ST_CONV) && fall &&
                       (rise_cnt == CNT_W'(SKIP) + CNT_W'(n_l));
    assign start     = ((state == ST_IDLE) && req) ||
                       ((state == ST_GAP) && gap_done && (req || pending));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req) nxt = ST_CONV;
            ST_CONV: if (frame_end) nxt = ST_GAP;
            ST_GAP:  if (gap_done) nxt = (req || pending) ? ST_CONV : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        cs_n   = (state != ST_CONV);
        gen_en = (state == ST_CONV);
    end

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_l       <= DIV_W'(MIN_HALF);
            n_l          <= NB_W'(RES_W);
            rise_cnt     <= '0;
            acc          <= '0;
            pending      <= 1'b0;
            gcnt         <= '0;
            result       <= '0;
            result_bits  <= '0;
            result_valid <= 1'b0;
        end else begin
            if (start) begin
                half_l   <= half_eff;
                n_l      <= n_eff;
                rise_cnt <= '0;
                acc      <= '0;
                pending  <= 1'b0;
            end else begin
                if (req && state != ST_IDLE) pending <= 1'b1;
                if (state == ST_CONV && cap) begin
                    rise_cnt <= rise_cnt + CNT_W'(1);
                    for (int b = 0; b < RES_W; b++) begin
                        if (rise_cnt == CNT_W'(SKIP + RES_W - 1 - b)) acc[b] <= sdi_s;
                    end
                end
            end
            gcnt <= (state == ST_GAP) ? gcnt + GAP_W'(1) : '0;
            result_valid <= frame_end;
            if (frame_end) begin
                result      <= acc;
                result_bits <= n_l;
            end
        end
    end

    // R10
    idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);
    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    // R7
    valid_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> cs_n);
    // R5
    bits_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> (result_bits >= NB_W'(MIN_BITS) && result_bits <= NB_W'(RES_W)));
    // R6
    low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ((result & ({RES_W{1'b1}} >> result_bits)) == '0));
endmodule

// File: tb/sim_adc_host_reader.sv
module sim_adc_host_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic [11:0] half_cyc = 12'd8;
    logic [3:0]  nbits = 4'd12;
    logic        sdi_m = 1'b1;
    logic        cs_n, sclk, result_valid;
    logic [11:0] result;
    logic [3:0]  result_bits;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    adc_host_reader u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .half_cyc(half_cyc), .nbits(nbits),
        .sdi(sdi_m), .cs_n(cs_n), .sclk(sclk), .result(result),
        .result_bits(result_bits), .result_valid(result_valid)
    );

    // converter model: null after second falling edge, then MSB first
    logic [11:0] cur_code = 12'h000;
    int fc = 0;
    always @(negedge cs_n) begin fc = 0; sdi_m = 1'b1; end
    always @(negedge sclk) begin
        if (!cs_n) begin
            logic v;
            fc++;
            v = sdi_m;
            if (fc == 2) v = 1'b0;
            else if (fc >= 3 && fc <= 14) v = cur_code[14-fc];
            else if (fc > 14 && fc <= 25) v = cur_code[fc-14];
            else if (fc > 25) v = 1'b0;
            #2 sdi_m = v;
        end
    end

    // port monitor
    logic prev_cs = 1'b1, prev_sc = 1'b0;
    int cs_run = 0, sc_run = 0, lo_len = 0, gap_len = 0, sc_hi = 0;
    int rises = 0, first_dly = 0, frames = 0;
    always @(negedge clk) begin
        if (cs_n != prev_cs) begin
            if (!prev_cs) lo_len = cs_run; else gap_len = cs_run;
            cs_run = 1;
            if (!cs_n) begin frames++; rises = 0; end
        end else cs_run++;
        if (sclk != prev_sc) begin
            if (prev_sc) sc_hi = sc_run;
            if (sclk) begin rises++; if (rises == 1) first_dly = cs_run - 1; end
            sc_run = 1;
        end else sc_run++;
        prev_cs = cs_n;
        prev_sc = sclk;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic int eff_h(int h);
        return (h < 8) ? 8 : h;
    endfunction
    function automatic int eff_n(int n);
        return (n < 3) ? 3 : ((n > 12) ? 12 : n);
    endfunction
    function automatic logic [11:0] exp_res(logic [11:0] c, int n);
        logic [11:0] m = 12'hFFF << (12 - n);
        return c & m;
    endfunction

    task automatic wait_valid(output bit ok);
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (result_valid) begin ok = 1; break; end
        end
        if (!ok) chk(0, "watchdog wait_valid", 0, 1);
    endtask

    task automatic one_frame(input logic [11:0] code, input int n, input int h);
        bit ok;
        int en, eh;
        en = eff_n(n);
        eh = eff_h(h);
        @(negedge clk);
        cur_code = code; nbits = 4'(n); half_cyc = 12'(h); req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        wait_valid(ok);
        if (!ok) return;
        chk(result == exp_res(code, en), "R4 R6 result", int'(result), int'(exp_res(code, en)));
        chk(int'(result_bits) == en, "R5 R6 result_bits", int'(result_bits), en);
        @(negedge clk);
        chk(!result_valid, "R7 valid width", int'(result_valid), 0);
        chk(lo_len == 2*eh*(3+en), "R4 cs low length", lo_len, 2*eh*(3+en));
        chk(rises == 3+en, "R4 rising edges", rises, 3+en);
        chk(sc_hi == eh, "R2 sclk high phase", sc_hi, eh);
        chk(first_dly == eh, "R3 cs to first rise", first_dly, eh);
        chk(!sclk && cs_n, "R10 idle after frame", int'(sclk), 0);
        repeat (2*eh + 2) @(negedge clk);
    endtask

    initial begin
        #3000000;
        chk(0, "watchdog global", 0, 1);
        summary();
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1
        chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
        chk(result_valid == 1'b0, "R1 result_valid", int'(result_valid), 0);
        chk(result == 12'h000, "R1 result", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corners
        one_frame(12'hFFF, 12, 8);
        one_frame(12'h000, 12, 10);
        one_frame(12'hA5C, 3, 9);
        one_frame(12'h5A3, 0, 1);    // R5 low clamp, R2 half clamp
        one_frame(12'h9E7, 15, 12);  // R5 high clamp
        one_frame(12'h801, 7, 8);

        // random frames
        for (int k = 0; k < 20; k++) begin
            one_frame(12'($urandom), int'($urandom_range(0, 15)), int'($urandom_range(1, 20)));
        end

        // R8 continuous: req held, n=12, h=8
        begin
            bit ok;
            int f0;
            cur_code = 12'h3C6; nbits = 4'd12; half_cyc = 12'd8;
            @(negedge clk);
            req = 1'b1;
            wait_valid(ok);
            chk(result == 12'h3C6, "R8 continuous result", int'(result), 12'h3C6);
            f0 = frames;
            wait_valid(ok);
            req = 1'b0;
            chk(result == 12'h3C6, "R8 continuous result 2", int'(result), 12'h3C6);
            chk(gap_len == 16, "R8 gap one period", gap_len, 16);
            chk(lo_len + gap_len == 16*16, "R8 sixteen-period frame", lo_len + gap_len, 256);
            chk(frames == f0 + 1, "R8 frame count", frames, f0 + 1);
            wait_valid(ok);
            repeat (40) @(negedge clk);
        end

        // R9 request landing on the closing edge of a frame
        begin
            bit ok;
            int f0, L;
            L = 2*8*(3+5);
            repeat (40) @(negedge clk);
            f0 = frames;
            cur_code = 12'hC3A; nbits = 4'd5; half_cyc = 12'd8;
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            repeat (L - 1) @(negedge clk);
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            chk(result_valid, "R9 R7 valid on closing edge", int'(result_valid), 1);
            chk(result == exp_res(12'hC3A, 5), "R9 first result", int'(result), int'(exp_res(12'hC3A, 5)));
            wait_valid(ok);
            chk(gap_len == 16, "R9 held request gap", gap_len, 16);
            chk(frames == f0 + 2, "R9 held request served", frames - f0, 2);
            repeat (60) @(negedge clk);
            chk(frames == f0 + 2 && cs_n, "R9 no extra frame", frames - f0, 2);
        end

        // R9 several requests merge into one follow-on frame
        begin
            bit ok;
            int f0;
            f0 = frames;
            cur_code = 12'h71E; nbits = 4'd4; half_cyc = 12'd8;
            req = 1'b1;
            @(negedge clk);
            req = 1'b0;
            repeat (20) @(negedge clk);
            req = 1'b1; @(negedge clk); req = 1'b0;
            repeat (30) @(negedge clk);
            req = 1'b1; @(negedge clk); req = 1'b0;
            wait_valid(ok);
            wait_valid(ok);
            repeat (200) @(negedge clk);
            chk(frames == f0 + 2, "R9 merged requests", frames - f0, 2);
            chk(result == exp_res(12'h71E, 4), "R9 merged result", int'(result), int'(exp_res(12'h71E, 4)));
        end

        summary();
    end
endmodule